// File: doc/BRIEF.md
# Debug-Channel Interrupt Controller

This block collects three level-sensitive interrupt sources and presents them on two independent active-high outputs: a normal interrupt and a fast interrupt. The sources are a software-generated request, a debug-channel receive request and a debug-channel transmit request. The two hardware requests arrive asynchronously and pass through a two-stage synchronizer. The software request comes from a single register bit that software sets and clears.

Each output channel has its own enable mask. Software can read the channel's raw source levels, read its masked status, and change its mask only through a write-one-to-set register and a write-one-to-clear register. The register bus is synchronous and word-wide. Writes take effect on the rising clock edge on which `bus_we` is high. Read data is a combinational function of `bus_addr`. A write whose byte enables are not all set is dropped.

Top module: `dbgcomm_intc`

## Requirements
- R1: Raw status reads at 0x44 (normal) and 0x64 (fast) return bit 0 = software bit, bit 1 = receive request, bit 2 = transmit request, and 0 in bits 31:3. A change on a request input becomes visible after the second rising clock edge that follows it.
- R2: Masked status reads at 0x40 (normal) and 0x60 (fast) return the raw status ANDed with that channel's enable mask.
- R3: A full write to 0x48 (normal) or 0x68 (fast) sets each enable bit whose write-data bit is 1 and leaves the others unchanged. A read of the same offset returns the mask.
- R4: A full write to 0x4C (normal) or 0x6C (fast) clears each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A full write to 0x50 with data bit 0 = 1 sets the software bit. A full write to 0x54 with bit 0 = 1 clears it. Other data bits have no effect. Reading 0x50 returns the software bit in bit 0.
- R6: A write whose byte enables are not 4'hF changes no enable bit and no software bit.
- R7: `irq_o` is the OR of the normal channel's masked status and `fiq_o` is the OR of the fast channel's masked status. Each channel uses only its own mask.
- R8: Reset clears both enable masks, the software bit and the synchronizers, so both outputs are low.
- R9: Reads of unmapped offsets and of the write-only clear offsets (0x4C, 0x54, 0x6C) return 0.
- R10: The software bit drives source 0 of both channels at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rx | input | 1 | Debug receive request, asynchronous level |
| req_tx | input | 1 | Debug transmit request, asynchronous level |
| bus_addr | input | AW (8) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF writes take effect |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
On every cycle, the assertions check the two-stage delay of each synchronizer stage. They check that a set pulse takes effect and a clear pulse wins in every mask register, and that a cycle with neither pulse holds the mask. They also check that a partial write leaves all state unchanged, that a masked status bit is never set without its enable, that an output is never high while its mask or its sources are all zero, and that read data has no reserved bits set. Only the bench's scenarios can show the address map. These include the reserved-bit and write-zero cases, the software bit reaching both channels at once, the exact cycle in which a request reaches raw status, and the clearing effect of a reset in mid-run.

// File: rtl/dbgcomm_intc_pkg.sv
package dbgcomm_intc_pkg;

  localparam int SRC_N = 3;

  localparam logic [7:0] OFS_NORM_BASE = 8'h40;
  localparam logic [7:0] OFS_FAST_BASE = 8'h60;
  localparam logic [7:0] OFS_SOFT_SET  = 8'h50;
  localparam logic [7:0] OFS_SOFT_CLR  = 8'h54;

  typedef enum logic [1:0] {
    CH_STAT  = 2'd0,
    CH_RAW   = 2'd1,
    CH_ENSET = 2'd2,
    CH_ENCLR = 2'd3
  } ch_reg_e;

  function automatic logic [SRC_N-1:0] masked_of(input logic [SRC_N-1:0] raw,
                                                 input logic [SRC_N-1:0] en);
    return raw & en;
  endfunction

  function automatic logic any_active(input logic [SRC_N-1:0] stat);
    return |stat;
  endfunction

endpackage

// File: rtl/dbgcomm_intc_sync.sv
module dbgcomm_intc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid <= '0;
      q   <= '0;
    end else begin
      mid <= d;
      q   <= mid;
    end
  end

  assert_sync_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mid == $past(d)));
  assert_sync_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q == $past(mid)));

endmodule

// File: rtl/dbgcomm_intc_w1reg.sv
module dbgcomm_intc_w1reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic [W-1:0] set_only;

  assign set_only = set_vec & ~clr_vec;

  always_comb begin
    q_d = (q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_only) |=> ((q & $past(set_only)) == $past(set_only)));
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((q & $past(clr_vec)) == '0));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(q));

endmodule

// File: rtl/dbgcomm_intc_chan.sv
module dbgcomm_intc_chan
  import dbgcomm_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] raw,
  input  logic [SRC_N-1:0] set_vec,
  input  logic [SRC_N-1:0] clr_vec,
  output logic [SRC_N-1:0] en_q,
  output logic [SRC_N-1:0] stat,
  output logic             int_o
);

  dbgcomm_intc_w1reg #(.W(SRC_N)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (en_q)
  );

  assign stat  = masked_of(raw, en_q);
  assign int_o = any_active(stat);

  assert_stat_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~en_q) == '0);
  assert_out_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !int_o);
  assert_out_needs_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !int_o);

endmodule

// File: rtl/dbgcomm_intc.sv
module dbgcomm_intc
  import dbgcomm_intc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rx,
  input  logic          req_tx,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [3:0]    bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);

  localparam int NCH    = 2;
  localparam int HW_SRC = SRC_N - 1;
  localparam logic [AW-1:0] SOFT_SET_A = AW'(OFS_SOFT_SET);
  localparam logic [AW-1:0] SOFT_CLR_A = AW'(OFS_SOFT_CLR);

  // Decoded bus events, brought out for the assertions
  logic                       full_wr;
  logic                       part_wr;
  logic [NCH-1:0]             ch_hit;
  ch_reg_e                    ch_sel;
  logic [NCH-1:0][SRC_N-1:0]  en_set;
  logic [NCH-1:0][SRC_N-1:0]  en_clr;
  logic [NCH-1:0][SRC_N-1:0]  en_q;
  logic [NCH-1:0][SRC_N-1:0]  stat;
  logic [NCH-1:0]             ch_int;
  logic                       soft_set;
  logic                       soft_clr;
  logic                       soft_q;
  logic [HW_SRC-1:0]          hw_sync;
  logic [SRC_N-1:0]           raw_vec;
  logic [DW-1:0]              rd_word;

  assign full_wr  = bus_we && (bus_be == 4'hF);
  assign part_wr  = bus_we && (bus_be != 4'hF);
  assign ch_sel   = ch_reg_e'(bus_addr[3:2]);
  assign soft_set = full_wr && (bus_addr == SOFT_SET_A) && bus_wdata[0];
  assign soft_clr = full_wr && (bus_addr == SOFT_CLR_A) && bus_wdata[0];

  dbgcomm_intc_sync #(.W(HW_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({req_tx, req_rx}),
    .q     (hw_sync)
  );

  dbgcomm_intc_w1reg #(.W(1)) u_soft (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (soft_set),
    .clr_vec (soft_clr),
    .q       (soft_q)
  );

  assign raw_vec = {hw_sync, soft_q};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = (c == 0) ? AW'(OFS_NORM_BASE) : AW'(OFS_FAST_BASE);

    assign ch_hit[c] = (bus_addr[AW-1:4] == BASE[AW-1:4]) && (bus_addr[1:0] == 2'b00);
    assign en_set[c] = (full_wr && ch_hit[c] && ch_sel == CH_ENSET) ? bus_wdata[SRC_N-1:0] : '0;
    assign en_clr[c] = (full_wr && ch_hit[c] && ch_sel == CH_ENCLR) ? bus_wdata[SRC_N-1:0] : '0;

    dbgcomm_intc_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (raw_vec),
      .set_vec (en_set[c]),
      .clr_vec (en_clr[c]),
      .en_q    (en_q[c]),
      .stat    (stat[c]),
      .int_o   (ch_int[c])
    );
  end

  // Read mux; clear offsets and unmapped offsets fall through to zero (R9)
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit[c]) begin
        case (ch_sel)
          CH_STAT:  rd_word = DW'(stat[c]);
          CH_RAW:   rd_word = DW'(raw_vec);
          CH_ENSET: rd_word = DW'(en_q[c]);
          default:  rd_word = '0;
        endcase
      end
    end
    if (bus_addr == SOFT_SET_A) rd_word = DW'(soft_q);
  end

  assign bus_rdata = rd_word;
  assign irq_o     = ch_int[0];
  assign fiq_o     = ch_int[1];

  assert_partial_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    part_wr |=> ($stable(soft_q) && $stable(en_q)));
  assert_rd_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:SRC_N] == '0);
  assert_soft_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !soft_q);

endmodule

// File: tb/dbgcomm_intc_bench.sv
module dbgcomm_intc_bench;

  typedef struct packed {
    logic [3:0]  tag;
    logic        rx;
    logic        tx;
    logic        we;
    logic [3:0]  be;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        irq;
    logic        fiq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0,1'b0,1'b0,4'hF,8'h44,32'd0,32'd0,1'b0,1'b0},
    '{4'd1, 1'b1,1'b0,1'b0,4'hF,8'h44,32'd0,32'd2,1'b0,1'b0},
    '{4'd1, 1'b1,1'b1,1'b0,4'hF,8'h44,32'd0,32'd6,1'b0,1'b0},
    '{4'd3, 1'b1,1'b1,1'b1,4'hF,8'h48,32'd2,32'd0,1'b1,1'b0},
    '{4'd2, 1'b1,1'b1,1'b0,4'hF,8'h40,32'd0,32'd2,1'b1,1'b0},
    '{4'd3, 1'b1,1'b1,1'b0,4'hF,8'h48,32'd0,32'd2,1'b1,1'b0},
    '{4'd7, 1'b0,1'b1,1'b0,4'hF,8'h40,32'd0,32'd0,1'b0,1'b0},
    '{4'd3, 1'b0,1'b1,1'b1,4'hF,8'h68,32'd5,32'd0,1'b0,1'b1},
    '{4'd2, 1'b0,1'b1,1'b0,4'hF,8'h60,32'd0,32'd4,1'b0,1'b1},
    '{4'd7, 1'b0,1'b0,1'b0,4'hF,8'h60,32'd0,32'd0,1'b0,1'b0},
    '{4'd5, 1'b0,1'b0,1'b1,4'hF,8'h50,32'd1,32'd0,1'b0,1'b1},
    '{4'd5, 1'b0,1'b0,1'b0,4'hF,8'h50,32'd0,32'd1,1'b0,1'b1},
    '{4'd10,1'b0,1'b0,1'b0,4'hF,8'h44,32'd0,32'd1,1'b0,1'b1},
    '{4'd10,1'b0,1'b0,1'b0,4'hF,8'h64,32'd0,32'd1,1'b0,1'b1},
    '{4'd3, 1'b0,1'b0,1'b1,4'hF,8'h48,32'd1,32'd0,1'b1,1'b1},
    '{4'd2, 1'b0,1'b0,1'b0,4'hF,8'h40,32'd0,32'd1,1'b1,1'b1},
    '{4'd4, 1'b0,1'b0,1'b1,4'hF,8'h6C,32'd1,32'd0,1'b1,1'b0},
    '{4'd3, 1'b0,1'b0,1'b0,4'hF,8'h68,32'd0,32'd4,1'b1,1'b0},
    '{4'd9, 1'b0,1'b0,1'b0,4'hF,8'h6C,32'd0,32'd0,1'b1,1'b0},
    '{4'd5, 1'b0,1'b0,1'b1,4'hF,8'h54,32'd1,32'd0,1'b0,1'b0},
    '{4'd5, 1'b0,1'b0,1'b0,4'hF,8'h50,32'd0,32'd0,1'b0,1'b0},
    '{4'd3, 1'b0,1'b0,1'b1,4'hF,8'h48,32'd0,32'd0,1'b0,1'b0},
    '{4'd3, 1'b0,1'b0,1'b0,4'hF,8'h48,32'd0,32'd3,1'b0,1'b0},
    '{4'd4, 1'b0,1'b0,1'b1,4'hF,8'h4C,32'd2,32'd0,1'b0,1'b0},
    '{4'd4, 1'b0,1'b0,1'b0,4'hF,8'h48,32'd0,32'd1,1'b0,1'b0},
    '{4'd9, 1'b0,1'b0,1'b0,4'hF,8'h70,32'd0,32'd0,1'b0,1'b0},
    '{4'd6, 1'b0,1'b0,1'b1,4'h3,8'h48,32'd7,32'd0,1'b0,1'b0},
    '{4'd6, 1'b0,1'b0,1'b0,4'hF,8'h48,32'd0,32'd1,1'b0,1'b0},
    '{4'd6, 1'b0,1'b0,1'b1,4'hE,8'h50,32'd1,32'd0,1'b0,1'b0},
    '{4'd6, 1'b0,1'b0,1'b0,4'hF,8'h50,32'd0,32'd0,1'b0,1'b0},
    '{4'd5, 1'b0,1'b0,1'b1,4'hF,8'h50,32'd2,32'd0,1'b0,1'b0},
    '{4'd5, 1'b0,1'b0,1'b0,4'hF,8'h50,32'd0,32'd0,1'b0,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rx = 1'b0;
  logic        req_tx = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        fiq_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dbgcomm_intc u_dbgcomm_intc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rx    (req_rx),
    .req_tx    (req_tx),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = 4'hF; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    req_rx = v.rx; req_tx = v.tx;
    bus_addr = v.addr; bus_wdata = v.data; bus_be = v.be; bus_we = v.we;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!v.we) chk(tag_name(v.tag), $sformatf("read %h", v.addr), bus_rdata, v.exp);
    chk(tag_name(v.tag), "irq_o", {31'd0, irq_o}, {31'd0, v.irq});
    chk(tag_name(v.tag), "fiq_o", {31'd0, fiq_o}, {31'd0, v.fiq});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: state after power-on reset
    read_chk("R8", 8'h48, 32'd0);
    read_chk("R8", 8'h68, 32'd0);
    read_chk("R8", 8'h50, 32'd0);
    chk("R8", "irq_o", {31'd0, irq_o}, 32'd0);
    chk("R8", "fiq_o", {31'd0, fiq_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R1: exact synchronizer latency; normal mask becomes 3'b011
    bus_write(8'h48, 32'd2);
    bus_addr = 8'h44;
    req_rx = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "raw after one edge", bus_rdata, 32'd0);
    chk("R7", "irq_o after one edge", {31'd0, irq_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "raw after two edges", bus_rdata, 32'd2);
    chk("R7", "irq_o after two edges", {31'd0, irq_o}, 32'd1);
    chk("R7", "fiq_o unmasked rx", {31'd0, fiq_o}, 32'd0);

    // R8: reset in mid-run clears masks, software bit and synchronizers
    bus_write(8'h50, 32'd1);
    @(negedge clk);
    req_rx = 1'b0;
    rst_n  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R8", 8'h48, 32'd0);
    read_chk("R8", 8'h68, 32'd0);
    read_chk("R8", 8'h50, 32'd0);
    read_chk("R8", 8'h44, 32'd0);
    chk("R8", "irq_o", {31'd0, irq_o}, 32'd0);
    chk("R8", "fiq_o", {31'd0, fiq_o}, 32'd0);

    finish_run();
  end

endmodule